// File: doc/BRIEF.md
# Crypto Engine Command Queue Decoder

This block sits between a host register write port and the datapath units of a block cipher accelerator. The host pushes 32-bit command words into a short in-order queue. The block takes each word off the queue in turn and decodes it. It then emits one-cycle start strobes, together with their decoded fields, to a DMA unit, to a block cipher engine and to a key-table loader. Commands that need an external address take that address from the word queued directly behind the opcode word.

While the cipher engine or a memory DMA is running, decoding stalls. Words stay in the queue until the running unit returns its done pulse. The host can see the queue state and the busy state. Three sticky interrupt causes record a malformed command, a completion marker and a write into a full queue. Each cause is masked into a single interrupt line and is cleared by writing ones.

Top module: `cmdq_decoder`

## Requirements
- R1: After reset `q_empty` is 1, and `eng_busy`, `int_stat`, `irq` and every start strobe are 0.
- R2: The queue holds up to DEPTH (5) words and decodes them in arrival order. A write while the queue is full is dropped and sets `int_stat[2]`.
- R3: The opcode is bits [31:26]. Opcode 0x10 takes the next queued word as its address and produces a `dma_setup` pulse with `op_addr` equal to that word.
- R4: Opcode 0x0E produces an `eng_start` pulse with `eng_nblk_m1` equal to bits [NBLK_W-1:0]. `eng_busy` rises with the pulse and falls on the cycle after `eng_done`. Queued commands are not decoded in between.
- R5: Opcode 0x22 takes the next queued word as its external address and produces `mdma_start`. `mdma_to_ext` is bit 25 (1 means internal RAM to external memory, 0 means the reverse) and `mdma_words` is bits [24:12]. `eng_busy` holds until `mdma_done`, and `eng_done` does not release it.
- R6: Opcode 0x15 produces a `key_load` pulse. `key_tbl_sel` is bits [25:24], `key_ram_sel` is bit 23, and `key_slot` is bits [19:17] of the table id field [20:17], which is 0x8 ORed with the slot.
- R7: Opcode 0x11 sets `int_stat[1]` and emits no strobe.
- R8: Any other opcode sets `int_stat[0]`, emits no strobe, is discarded, and leaves the next word to be decoded on the following cycle.
- R9: Each 1 bit in `int_clr` clears the matching `int_stat` bit. A cause raised in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when some `int_stat` bit is set and its `int_en` bit is 1.
- R11: `q_empty` is 1 exactly when no word is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Push `cmd_data` into the queue |
| cmd_data | input | 32 | Command or operand word |
| q_empty | output | 1 | No word queued |
| eng_busy | output | 1 | Cipher engine or memory DMA running |
| int_en | input | 3 | Interrupt enable mask |
| int_clr | input | 3 | Write-one-to-clear for `int_stat` |
| int_stat | output | 3 | Causes: [0] bad opcode, [1] completion marker, [2] queue overflow |
| irq | output | 1 | Masked interrupt |
| dma_setup | output | 1 | DMA input buffer setup strobe |
| op_addr | output | 32 | Address operand of the last two-word command |
| eng_start | output | 1 | Cipher engine start strobe |
| eng_nblk_m1 | output | NBLK_W | Block count minus one |
| eng_done | input | 1 | Engine finished its final block |
| mdma_start | output | 1 | Memory DMA start strobe |
| mdma_to_ext | output | 1 | Memory DMA direction |
| mdma_words | output | WCNT_W | Memory DMA word count |
| mdma_done | input | 1 | Memory DMA finished |
| key_load | output | 1 | Key table load strobe |
| key_tbl_sel | output | 2 | Table select |
| key_ram_sel | output | 1 | Internal RAM select |
| key_slot | output | 3 | Key slot number |

## Verification
A word written at one clock edge enters the queue at that edge and is decoded at the next edge. A single-word command therefore shows its strobe or its interrupt bit one cycle after the write. A two-word command shows its strobe one cycle after the write of its operand word. The end of `eng_busy` comes one cycle after the done pulse, and a command queued behind it decodes one cycle later still. The bench drives inputs on falling edges and samples exactly one falling edge after the rising edge that is due to produce each result. A five-word backlog drains at one command per cycle, and each word is checked in turn.

// File: rtl/cmdq_decoder.sv
module cmdq_decoder #(
  parameter int DEPTH  = 5,
  parameter int NBLK_W = 12,
  parameter int WCNT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_data,
  output logic              q_empty,
  output logic              eng_busy,
  input  logic [2:0]        int_en,
  input  logic [2:0]        int_clr,
  output logic [2:0]        int_stat,
  output logic              irq,
  output logic              dma_setup,
  output logic [31:0]       op_addr,
  output logic              eng_start,
  output logic [NBLK_W-1:0] eng_nblk_m1,
  input  logic              eng_done,
  output logic              mdma_start,
  output logic              mdma_to_ext,
  output logic [WCNT_W-1:0] mdma_words,
  input  logic              mdma_done,
  output logic              key_load,
  output logic [1:0]        key_tbl_sel,
  output logic              key_ram_sel,
  output logic [2:0]        key_slot
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [5:0] OP_DMA = 6'h10, OP_ENG = 6'h0E, OP_CMPL = 6'h11,
                         OP_KEY = 6'h15, OP_MDMA = 6'h22;

  typedef enum logic [1:0] {S_IDLE, S_OPND, S_ENG, S_MDMA} st_t;

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  st_t           st;
  logic          opnd_mdma;
  logic          push, pop;
  logic [31:0]   head;
  logic [5:0]    op;
  logic [2:0]    int_set;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head     = mem[rp];
  assign op       = head[31:26];
  assign q_empty  = (cnt == '0);
  assign push     = cmd_wr && (cnt != FULL);
  assign pop      = (st == S_IDLE || st == S_OPND) && !q_empty;
  assign eng_busy = (st == S_ENG) || (st == S_MDMA);
  assign irq      = |(int_stat & int_en);

  always_comb begin
    int_set    = '0;
    int_set[2] = cmd_wr && (cnt == FULL);
    if (pop && st == S_IDLE) begin
      int_set[1] = (op == OP_CMPL);
      int_set[0] = !(op inside {OP_DMA, OP_ENG, OP_CMPL, OP_KEY, OP_MDMA});
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= cmd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; st <= S_IDLE; opnd_mdma <= 1'b0;
      int_stat <= '0;
      dma_setup <= 1'b0; eng_start <= 1'b0; mdma_start <= 1'b0; key_load <= 1'b0;
      op_addr <= '0; eng_nblk_m1 <= '0; mdma_to_ext <= 1'b0; mdma_words <= '0;
      key_tbl_sel <= '0; key_ram_sel <= 1'b0; key_slot <= '0;
    end else begin
      dma_setup <= 1'b0; eng_start <= 1'b0; mdma_start <= 1'b0; key_load <= 1'b0;
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt      <= cnt + CW'(push) - CW'(pop);
      int_stat <= (int_stat & ~int_clr) | int_set;
      case (st)
        S_IDLE: if (pop) begin
          case (op)
            OP_DMA: begin opnd_mdma <= 1'b0; st <= S_OPND; end
            OP_MDMA: begin
              opnd_mdma   <= 1'b1;
              mdma_to_ext <= head[25];
              mdma_words  <= head[12 +: WCNT_W];
              st          <= S_OPND;
            end
            OP_ENG: begin
              eng_start   <= 1'b1;
              eng_nblk_m1 <= head[NBLK_W-1:0];
              st          <= S_ENG;
            end
            OP_KEY: begin
              key_load    <= 1'b1;
              key_tbl_sel <= head[25:24];
              key_ram_sel <= head[23];
              key_slot    <= head[19:17];
            end
            default: ;
          endcase
        end
        S_OPND: if (pop) begin
          op_addr <= head;
          if (opnd_mdma) begin mdma_start <= 1'b1; st <= S_MDMA; end
          else begin dma_setup <= 1'b1; st <= S_IDLE; end
        end
        S_ENG:  if (eng_done)  st <= S_IDLE;
        S_MDMA: if (mdma_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r2_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cnt == FULL) |=> int_stat[2]);
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_setup, eng_start, mdma_start, key_load}));
  a_r4_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_busy);
  a_r4_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |-> $past(eng_done || mdma_done));
  a_r11_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !cmd_wr) |=> q_empty);
endmodule

// File: tb/cmdq_decoder_bench.sv
module cmdq_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK_W = 12;
  localparam int WCNT_W = 13;

  logic clk = 1'b0, rst_n = 1'b0, cmd_wr = 1'b0, eng_done = 1'b0, mdma_done = 1'b0;
  logic [31:0] cmd_data = '0;
  logic [2:0]  int_en = '0, int_clr = '0;
  logic q_empty, eng_busy, irq, dma_setup, eng_start, mdma_start, mdma_to_ext, key_load, key_ram_sel;
  logic [2:0] int_stat, key_slot;
  logic [1:0] key_tbl_sel;
  logic [31:0] op_addr;
  logic [NBLK_W-1:0] eng_nblk_m1;
  logic [WCNT_W-1:0] mdma_words;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmdq_decoder #(.DEPTH(5), .NBLK_W(NBLK_W), .WCNT_W(WCNT_W)) u_cmdq_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .q_empty(q_empty), .eng_busy(eng_busy), .int_en(int_en), .int_clr(int_clr),
    .int_stat(int_stat), .irq(irq), .dma_setup(dma_setup), .op_addr(op_addr),
    .eng_start(eng_start), .eng_nblk_m1(eng_nblk_m1), .eng_done(eng_done),
    .mdma_start(mdma_start), .mdma_to_ext(mdma_to_ext), .mdma_words(mdma_words),
    .mdma_done(mdma_done), .key_load(key_load), .key_tbl_sel(key_tbl_sel),
    .key_ram_sel(key_ram_sel), .key_slot(key_slot));

  function automatic logic [31:0] w_key(logic [1:0] tbl, logic ram, logic [2:0] slot);
    return (32'h15 << 26) | (32'(tbl) << 24) | (32'(ram) << 23) | (32'({1'b1, slot}) << 17);
  endfunction
  function automatic logic [31:0] w_eng(logic [NBLK_W-1:0] n);
    return (32'h0E << 26) | 32'(n);
  endfunction
  function automatic logic [31:0] w_mdma(logic dir, logic [WCNT_W-1:0] n);
    return (32'h22 << 26) | (32'(dir) << 25) | (32'(n) << 12);
  endfunction
  function automatic logic [5:0] bad_op(logic [5:0] r);
    return (r inside {6'h0E, 6'h10, 6'h11, 6'h15, 6'h22}) ? 6'h3F : r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w);
    cmd_wr = 1'b1; cmd_data = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic pulse_eng;  eng_done = 1'b1;  tick(); eng_done = 1'b0;  endtask
  task automatic pulse_mdma; mdma_done = 1'b1; tick(); mdma_done = 1'b0; endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed, a, w;
    logic [1:0] tbl; logic ram; logic [2:0] slot;
    logic [NBLK_W-1:0] nb; logic [WCNT_W-1:0] nw;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 q_empty", 32'(q_empty), 1);
    chk("R1 busy", 32'(eng_busy), 0);
    chk("R1 int_stat", 32'(int_stat), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 strobes", 32'({dma_setup, eng_start, mdma_start, key_load}), 0);

    // R6 random key loads
    for (int i = 0; i < 20; i++) begin
      tbl = 2'($urandom); ram = 1'($urandom); slot = 3'($urandom);
      push(w_key(tbl, ram, slot)); tick();
      chk("R6 key_load", 32'(key_load), 1);
      chk("R6 tbl_sel", 32'(key_tbl_sel), 32'(tbl));
      chk("R6 ram_sel", 32'(key_ram_sel), 32'(ram));
      chk("R6 slot", 32'(key_slot), 32'(slot));
    end

    // R3 DMA setup with operand
    for (int i = 0; i < 8; i++) begin
      a = $urandom;
      push(32'h10 << 26); push(a); tick();
      chk("R3 dma_setup", 32'(dma_setup), 1);
      chk("R3 op_addr", op_addr, a);
      chk("R3 not busy", 32'(eng_busy), 0);
    end

    // R4 engine start and stall
    for (int i = 0; i < 6; i++) begin
      nb = (i == 0) ? '0 : (i == 1) ? '1 : NBLK_W'($urandom);
      push(w_eng(nb)); tick();
      chk("R4 eng_start", 32'(eng_start), 1);
      chk("R4 nblk", 32'(eng_nblk_m1), 32'(nb));
      chk("R4 busy", 32'(eng_busy), 1);
      push(w_key(2'd3, 1'b1, 3'd6));
      repeat (3) tick();
      chk("R4 stalled key_load", 32'(key_load), 0);
      chk("R4 stalled queue", 32'(q_empty), 0);
      chk("R4 still busy", 32'(eng_busy), 1);
      pulse_eng();
      chk("R4 busy released", 32'(eng_busy), 0);
      tick();
      chk("R4 queued key after done", 32'(key_load), 1);
      chk("R4 queued slot", 32'(key_slot), 6);
    end

    // R5 memory DMA both directions
    for (int i = 0; i < 6; i++) begin
      ram = 1'(i); nw = (i < 2) ? 13'd16 : WCNT_W'($urandom); a = $urandom;
      push(w_mdma(ram, nw)); push(a); tick();
      chk("R5 mdma_start", 32'(mdma_start), 1);
      chk("R5 dir", 32'(mdma_to_ext), 32'(ram));
      chk("R5 words", 32'(mdma_words), 32'(nw));
      chk("R5 addr", op_addr, a);
      chk("R5 busy", 32'(eng_busy), 1);
      pulse_eng();
      chk("R5 eng_done ignored", 32'(eng_busy), 1);
      pulse_mdma();
      chk("R5 busy released", 32'(eng_busy), 0);
    end

    // R7 completion marker, R10 masking, R9 clear
    push(32'h11 << 26); tick();
    chk("R7 int_stat", 32'(int_stat), 3'b010);
    chk("R7 no strobe", 32'({dma_setup, eng_start, mdma_start, key_load}), 0);
    chk("R10 irq masked", 32'(irq), 0);
    int_en = 3'b010; #1;
    chk("R10 irq enabled", 32'(irq), 1);
    int_en = 3'b101; #1;
    chk("R10 irq other mask", 32'(irq), 0);
    int_clr = 3'b010; tick(); int_clr = '0;
    chk("R9 cleared", 32'(int_stat), 0);

    // R8 unknown opcodes followed immediately by a key load
    for (int i = 0; i < 10; i++) begin
      w = (32'(bad_op(6'($urandom))) << 26) | ($urandom & 32'h03FF_FFFF);
      slot = 3'($urandom);
      push(w); tick();
      chk("R8 err flag", 32'(int_stat[0]), 1);
      chk("R8 no strobe", 32'({dma_setup, eng_start, mdma_start, key_load}), 0);
      chk("R8 discarded", 32'(q_empty), 1);
      push(w); push(w_key(2'd1, 1'b0, slot)); tick();
      chk("R8 next decoded", 32'(key_load), 1);
      chk("R8 next slot", 32'(key_slot), 32'(slot));
      int_clr = 3'b001; tick(); int_clr = '0;
      chk("R9 err cleared", 32'(int_stat), 0);
    end

    // R9 set wins over clear in the same cycle
    push(32'h11 << 26);
    int_clr = 3'b010; tick(); int_clr = '0;
    chk("R9 set wins", 32'(int_stat[1]), 1);
    int_clr = 3'b111; tick(); int_clr = '0;

    // R2 overflow and in-order drain
    push(w_eng(12'd3)); tick();
    for (int i = 0; i < 5; i++) push(w_key(2'd0, 1'b0, 3'(i)));
    chk("R2 no overflow at depth", 32'(int_stat[2]), 0);
    push(w_key(2'd0, 1'b0, 3'd7));
    chk("R2 overflow flag", 32'(int_stat[2]), 1);
    chk("R11 queue not empty", 32'(q_empty), 0);
    pulse_eng();
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R2 drain strobe", 32'(key_load), 1);
      chk("R2 drain order", 32'(key_slot), 32'(i));
    end
    tick();
    chk("R2 dropped word absent", 32'(key_load), 0);
    chk("R11 queue empty", 32'(q_empty), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule